// File: doc/BRIEF.md
# Bidirectional Pad Boundary-Scan Register

This block gives a set of bidirectional pads a boundary-scan path that a test host runs through a four-wire serial test port. A sixteen-state controller, stepped by the test-mode select input on each rising test clock, picks between an instruction path and several data paths. The instruction path is a 3-bit register. The data paths are a per-pad cell chain, a fixed 32-bit identifier and a single-bit bypass stage.

Every pad is modelled as three separate signals: the value seen at the pad, the value driven onto it and its driver enable. Each pad owns two cells in the chain, one for its data and one for its 3-state control. In functional operation the pads follow the core's output and enable. The chain can snapshot all pads at once, or preload values into shadow latches. Under the external-test instruction those latches take over the pads. A pad whose enable latch is set drives its data latch onto the board. A pad whose enable latch is clear is sampled, so that board wiring between devices can be probed for opens and stuck nets.

Top module: `bscan_pad_chain`

## Requirements
- R1: The controller follows the standard sixteen-state test-port graph on rising test clock edges, and five consecutive cycles with test-mode select high reach Test-Logic-Reset from any state.
- R2: The instruction register is 3 bits wide and is shifted least significant bit first. Capture-IR loads the value 3'b001. The encodings are EXTEST=3'b000, SAMPLE/PRELOAD=3'b001, IDCODE=3'b110 and BYPASS=3'b111.
- R3: An asynchronous reset or the Test-Logic-Reset state makes IDCODE the active instruction and clears every pad update latch, so that no pad is driven from the latches.
- R4: Under IDCODE, Capture-DR loads the 32-bit code {version[3:0], part[9:0], family[5:0], manufacturer[10:0], 1'b1}. The code is shifted out least significant bit first, so the first bit out is 1.
- R5: Under BYPASS, and under the unused or vendor codes 3'b010, 3'b011, 3'b100 and 3'b101, a single stage sits between the serial input and output. That stage captures 0.
- R6: The pad chain has two cells per pad. Bit 2k holds the data of pad k and bit 2k+1 holds its enable. Bit 0 is shifted out first, and serial input enters at the top bit.
- R7: Under SAMPLE/PRELOAD, Capture-DR loads every pad's input value into its data cell and every core enable value into its enable cell, all in the same cycle.
- R8: The pad update latches load from the chain only in Update-DR, on the falling test clock, and only under SAMPLE/PRELOAD or EXTEST. All pads load at once. Update-DR under any other instruction leaves them unchanged.
- R9: Under EXTEST, each pad's driver enable comes from its enable latch and each pad's driven value comes from its data latch.
- R10: Under EXTEST, Capture-DR loads a pad's enable cell from its enable latch. The data cell takes the data latch value when the enable latch is set, and the pad input value when it is clear.
- R11: Under any instruction other than EXTEST, pad output and enable follow the core's functional output and enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low test reset |
| tms_i | input | 1 | Test-mode select |
| tdi_i | input | 1 | Serial test data in |
| tdo_o | output | 1 | Serial test data out, valid in Shift-IR and Shift-DR |
| core_out_i | input | N_PADS | Functional output value per pad from the core |
| core_oe_i | input | N_PADS | Functional driver enable per pad from the core |
| pad_in_i | input | N_PADS | Value observed at each pad |
| pad_out_o | output | N_PADS | Value driven onto each pad |
| pad_oe_o | output | N_PADS | Driver enable for each pad |

## Verification
Capture takes effect on the rising edge that leaves Capture-DR or Capture-IR. The first captured bit therefore sits on the serial output for the whole first Shift cycle. Each later bit appears one rising edge after the one before it. The bench reads the serial output just before the rising edge that shifts each bit away.

Update latches and the instruction change on the falling edge inside Update-DR or Update-IR. Pad outputs settle half a clock after the state is entered. The bench checks pads only after returning to Run-Test-Idle, well clear of both edges.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] IR_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] IR_SAMPLE  = 3'b001;
  localparam logic [IR_W-1:0] IR_IDCODE  = 3'b110;
  localparam logic [IR_W-1:0] IR_BYPASS  = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [1:0] {
    DR_BYPASS,
    DR_IDCODE,
    DR_PADS
  } dr_sel_e;

  function automatic dr_sel_e decode_ir(input logic [IR_W-1:0] ir);
    dr_sel_e sel;
    case (ir)
      IR_EXTEST, IR_SAMPLE: sel = DR_PADS;
      IR_IDCODE:            sel = DR_IDCODE;
      default:              sel = DR_BYPASS;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/bscan_tap.sv
module bscan_tap
  import bscan_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);

  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TLR:    state_d = tms_i ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms_i ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms_i ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms_i ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms_i ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms_i ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms_i ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms_i ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms_i ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms_i ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms_i ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms_i ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_TLR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  p_tlr_hold_r1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_TLR && tms_i) |=> state_q == ST_TLR);

  p_sel_ir_escape_r1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_SEL_IR && tms_i) |=> state_q == ST_TLR);

endmodule

// File: rtl/bscan_ir.sv
module bscan_ir
  import bscan_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] ir_o,
  output logic            so_o
);

  logic [IR_W-1:0] sr_q;
  logic [IR_W-1:0] ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (state_i == ST_CAP_IR) begin
      sr_q <= IR_CAPTURE;
    end else if (state_i == ST_SH_IR) begin
      sr_q <= {tdi_i, sr_q[IR_W-1:1]};
    end
  end

  // instruction changes on the falling edge only
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni)                   ir_q <= IR_IDCODE;
    else if (state_i == ST_TLR)    ir_q <= IR_IDCODE;
    else if (state_i == ST_UPD_IR) ir_q <= sr_q;
  end

  assign ir_o = ir_q;
  assign so_o = sr_q[0];

  p_ir_capture_r2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    state_i == ST_CAP_IR |=> sr_q == IR_CAPTURE);

  p_idcode_on_tlr_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    state_i == ST_TLR |=> ir_q == IR_IDCODE);

  p_ir_stable_r2: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !$stable(ir_q) |-> (state_i == ST_UPD_IR || state_i == ST_TLR));

endmodule

// File: rtl/bscan_idcode.sv
module bscan_idcode
  import bscan_pkg::*;
#(
  parameter logic [3:0]  ID_VERSION = 4'h2,
  parameter logic [9:0]  ID_PART    = 10'h1A3,
  parameter logic [5:0]  ID_FAMILY  = 6'h2C,
  parameter logic [10:0] ID_MFR     = 11'h05B
) (
  input  logic       tck_i,
  input  logic       rst_ni,
  input  tap_state_e state_i,
  input  logic       sel_i,
  input  logic       tdi_i,
  output logic       so_o
);

  localparam int ID_W = 32;
  localparam logic [ID_W-1:0] ID_CODE = {ID_VERSION, ID_PART, ID_FAMILY, ID_MFR, 1'b1};

  logic [ID_W-1:0] sr_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (sel_i && state_i == ST_CAP_DR) begin
      sr_q <= ID_CODE;
    end else if (sel_i && state_i == ST_SH_DR) begin
      sr_q <= {tdi_i, sr_q[ID_W-1:1]};
    end
  end

  assign so_o = sr_q[0];

  p_id_lsb_one_r4: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (sel_i && state_i == ST_CAP_DR) |=> sr_q[0]);

endmodule

// File: rtl/bscan_cell_chain.sv
module bscan_cell_chain
  import bscan_pkg::*;
#(
  parameter int N_PADS = 4
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  tap_state_e        state_i,
  input  logic              sel_i,
  input  logic              extest_i,
  input  logic              tdi_i,
  input  logic [N_PADS-1:0] pad_in_i,
  input  logic [N_PADS-1:0] core_oe_i,
  output logic [N_PADS-1:0] upd_data_o,
  output logic [N_PADS-1:0] upd_oe_o,
  output logic              so_o
);

  localparam int CHAIN_W = 2 * N_PADS;

  logic [CHAIN_W-1:0] sr_q;
  logic [CHAIN_W-1:0] cap_d;
  logic [N_PADS-1:0]  upd_data_q, upd_oe_q;

  for (genvar k = 0; k < N_PADS; k++) begin : g_pad
    always_comb begin
      if (extest_i) begin
        cap_d[2*k]   = upd_oe_q[k] ? upd_data_q[k] : pad_in_i[k];
        cap_d[2*k+1] = upd_oe_q[k];
      end else begin
        cap_d[2*k]   = pad_in_i[k];
        cap_d[2*k+1] = core_oe_i[k];
      end
    end

    always_ff @(negedge tck_i or negedge rst_ni) begin
      if (!rst_ni) begin
        upd_data_q[k] <= 1'b0;
        upd_oe_q[k]   <= 1'b0;
      end else if (state_i == ST_TLR) begin
        upd_data_q[k] <= 1'b0;
        upd_oe_q[k]   <= 1'b0;
      end else if (sel_i && state_i == ST_UPD_DR) begin
        upd_data_q[k] <= sr_q[2*k];
        upd_oe_q[k]   <= sr_q[2*k+1];
      end
    end

    p_extest_cap_en_r10: assert property (@(posedge tck_i) disable iff (!rst_ni)
      (sel_i && extest_i && state_i == ST_CAP_DR) |=> sr_q[2*k+1] == upd_oe_q[k]);
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (sel_i && state_i == ST_CAP_DR) begin
      sr_q <= cap_d;
    end else if (sel_i && state_i == ST_SH_DR) begin
      sr_q <= {tdi_i, sr_q[CHAIN_W-1:1]};
    end
  end

  assign upd_data_o = upd_data_q;
  assign upd_oe_o   = upd_oe_q;
  assign so_o       = sr_q[0];

  p_upd_only_in_update_r8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !$stable({upd_data_q, upd_oe_q}) |-> (state_i == ST_UPD_DR || state_i == ST_TLR));

  p_tlr_clears_r3: assert property (@(posedge tck_i) disable iff (!rst_ni)
    state_i == ST_TLR |=> upd_oe_q == '0);

endmodule

// File: rtl/bscan_pad_chain.sv
module bscan_pad_chain
  import bscan_pkg::*;
#(
  parameter int          N_PADS     = 4,
  parameter logic [3:0]  ID_VERSION = 4'h2,
  parameter logic [9:0]  ID_PART    = 10'h1A3,
  parameter logic [5:0]  ID_FAMILY  = 6'h2C,
  parameter logic [10:0] ID_MFR     = 11'h05B
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tms_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  input  logic [N_PADS-1:0] core_out_i,
  input  logic [N_PADS-1:0] core_oe_i,
  input  logic [N_PADS-1:0] pad_in_i,
  output logic [N_PADS-1:0] pad_out_o,
  output logic [N_PADS-1:0] pad_oe_o
);

  tap_state_e        state;
  logic [IR_W-1:0]   ir;
  logic              ir_so, id_so, pads_so;
  logic              bypass_q;
  logic [N_PADS-1:0] upd_data, upd_oe;
  dr_sel_e           dr_sel;
  logic              extest;

  assign dr_sel = decode_ir(ir);
  assign extest = (ir == IR_EXTEST);

  bscan_tap i_tap (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .tms_i   (tms_i),
    .state_o (state)
  );

  bscan_ir i_ir (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .tdi_i   (tdi_i),
    .ir_o    (ir),
    .so_o    (ir_so)
  );

  bscan_idcode #(
    .ID_VERSION (ID_VERSION),
    .ID_PART    (ID_PART),
    .ID_FAMILY  (ID_FAMILY),
    .ID_MFR     (ID_MFR)
  ) i_idcode (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .sel_i   (dr_sel == DR_IDCODE),
    .tdi_i   (tdi_i),
    .so_o    (id_so)
  );

  bscan_cell_chain #(
    .N_PADS (N_PADS)
  ) i_chain (
    .tck_i      (tck_i),
    .rst_ni     (rst_ni),
    .state_i    (state),
    .sel_i      (dr_sel == DR_PADS),
    .extest_i   (extest),
    .tdi_i      (tdi_i),
    .pad_in_i   (pad_in_i),
    .core_oe_i  (core_oe_i),
    .upd_data_o (upd_data),
    .upd_oe_o   (upd_oe),
    .so_o       (pads_so)
  );

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bypass_q <= 1'b0;
    end else if (dr_sel == DR_BYPASS) begin
      if (state == ST_CAP_DR)     bypass_q <= 1'b0;
      else if (state == ST_SH_DR) bypass_q <= tdi_i;
    end
  end

  always_comb begin
    tdo_o = 1'b0;
    if (state == ST_SH_IR) begin
      tdo_o = ir_so;
    end else if (state == ST_SH_DR) begin
      unique case (dr_sel)
        DR_IDCODE: tdo_o = id_so;
        DR_PADS:   tdo_o = pads_so;
        default:   tdo_o = bypass_q;
      endcase
    end
  end

  assign pad_out_o = extest ? upd_data : core_out_i;
  assign pad_oe_o  = extest ? upd_oe   : core_oe_i;

  p_bypass_cap_zero_r5: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (dr_sel == DR_BYPASS && state == ST_CAP_DR) |=> !bypass_q);

  p_tdo_quiet_r6: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state != ST_SH_DR && state != ST_SH_IR) |-> !tdo_o);

endmodule

// File: tb/test_bscan_pad_chain.sv
`timescale 1ns/1ps
module test_bscan_pad_chain;

  localparam int N = 4;
  localparam logic [31:0] EXP_ID = {4'h2, 10'h1A3, 6'h2C, 11'h05B, 1'b1};

  // {pad_in[15:12], core_oe[11:8], preload[7:0]}
  localparam logic [15:0] VEC [0:5] = '{
    16'hA53C, 16'h5AC3, 16'hF0FF, 16'h0F00, 16'h3996, 16'hC669
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, tms, tdi, tdo;
  logic [N-1:0] core_out, core_oe, pad_in, pad_out, pad_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  bscan_pad_chain i_bscan_pad_chain (
    .tck_i      (clk),
    .rst_ni     (rst_n),
    .tms_i      (tms),
    .tdi_i      (tdi),
    .tdo_o      (tdo),
    .core_out_i (core_out),
    .core_oe_i  (core_oe),
    .pad_in_i   (pad_in),
    .pad_out_o  (pad_out),
    .pad_oe_o   (pad_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge clk);
    @(negedge clk);
    #0.5;
  endtask

  // from Run-Test-Idle, back to Run-Test-Idle
  task automatic load_ir(input logic [2:0] v, output logic [2:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      tick(i == 2, v[i]);
    end
    tick(1, 0);
    tick(0, 0);
  endtask

  task automatic scan_dr(input logic [31:0] v, input int len, output logic [31:0] cap);
    cap = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < len; i++) begin
      cap[i] = tdo;
      tick(i == len - 1, v[i]);
    end
    tick(1, 0);
    tick(0, 0);
  endtask

  function automatic logic [7:0] sample_exp(input logic [3:0] pin, input logic [3:0] oe);
    logic [7:0] r;
    for (int k = 0; k < N; k++) begin
      r[2*k]   = pin[k];
      r[2*k+1] = oe[k];
    end
    return r;
  endfunction

  function automatic logic [7:0] extest_exp(input logic [7:0] pre, input logic [3:0] pin);
    logic [7:0] r;
    for (int k = 0; k < N; k++) begin
      r[2*k]   = pre[2*k+1] ? pre[2*k] : pin[k];
      r[2*k+1] = pre[2*k+1];
    end
    return r;
  endfunction

  function automatic logic [3:0] even_bits(input logic [7:0] v);
    logic [3:0] r;
    for (int k = 0; k < N; k++) r[k] = v[2*k];
    return r;
  endfunction

  function automatic logic [3:0] odd_bits(input logic [7:0] v);
    logic [3:0] r;
    for (int k = 0; k < N; k++) r[k] = v[2*k+1];
    return r;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0]  ic;
    logic [31:0] cap;
    rst_n = 0; tms = 1; tdi = 0;
    core_out = 4'b0110; core_oe = 4'b1010; pad_in = 4'b0011;
    repeat (3) @(negedge clk);
    #0.5;
    // R3: reset state, pads follow core, IDCODE active
    chk("R3 pad_oe after reset", 32'(pad_oe), 32'(core_oe));
    chk("R11 pad_out after reset", 32'(pad_out), 32'(core_out));
    rst_n = 1;
    tick(0, 0);

    scan_dr('0, 32, cap);
    chk("R4 idcode after reset", cap, EXP_ID);

    load_ir(3'b110, ic);
    chk("R2 ir capture", 32'(ic), 32'(3'b001));

    // R5: bypass delays by one stage, first bit is 0
    load_ir(3'b111, ic);
    scan_dr(32'h0000_00B5, 9, cap);
    chk("R5 bypass 111", cap, {23'b0, 8'hB5, 1'b0});
    load_ir(3'b100, ic);
    scan_dr(32'h0000_004D, 9, cap);
    chk("R5 bypass vendor 100", cap, {23'b0, 8'h4D, 1'b0});
    load_ir(3'b011, ic);
    scan_dr(32'h0000_01F2, 10, cap);
    chk("R5 bypass vendor 011", cap, {22'b0, 9'h1F2, 1'b0});

    // table walk: R6 R7 R8 R9 R10 R11
    foreach (VEC[e]) begin
      logic [3:0] pin, oe;
      logic [7:0] pre;
      pin = VEC[e][15:12]; oe = VEC[e][11:8]; pre = VEC[e][7:0];
      pad_in = pin; core_oe = oe; core_out = ~pin;
      load_ir(3'b001, ic);
      scan_dr(32'(pre), 8, cap);
      chk("R7 sample capture", cap, 32'(sample_exp(pin, oe)));
      chk("R11 pads follow core in sample", 32'({pad_out, pad_oe}), 32'({core_out, core_oe}));
      load_ir(3'b000, ic);
      chk("R9 extest pad_oe from preload", 32'(pad_oe), 32'(odd_bits(pre)));
      chk("R9 extest pad_out from preload", 32'(pad_out), 32'(even_bits(pre)));
      scan_dr('0, 8, cap);
      chk("R10 extest capture", cap, 32'(extest_exp(pre, pin)));
      chk("R8 update zeros all pads", 32'({pad_out, pad_oe}), 32'(0));
    end

    // R8: update under BYPASS leaves latches alone
    load_ir(3'b001, ic);
    scan_dr(32'h0000_00FF, 8, cap);
    load_ir(3'b111, ic);
    scan_dr(32'h0, 8, cap);
    load_ir(3'b000, ic);
    chk("R8 bypass update ignored", 32'({pad_out, pad_oe}), 32'(8'hFF));

    // R1 R3: five TMS high from Shift-DR reach reset; IDCODE back, latches cleared
    core_oe = 4'b0101; core_out = 4'b1001;
    tick(1, 0); tick(0, 0); tick(0, 0);
    repeat (5) tick(1, 0);
    tick(0, 0);
    chk("R3 pads follow core after TLR", 32'({pad_out, pad_oe}), 32'({core_out, core_oe}));
    scan_dr('0, 32, cap);
    chk("R1 idcode after five tms", cap, EXP_ID);
    load_ir(3'b000, ic);
    chk("R3 latches cleared by TLR", 32'({pad_out, pad_oe}), 32'(0));

    // R6: bit 0 of the chain leaves first, tdi lands at the top
    load_ir(3'b001, ic);
    pad_in = 4'b0001; core_oe = 4'b0000;
    scan_dr(32'h0000_0080, 8, cap);
    chk("R6 chain order", cap, 32'h0000_0001);
    load_ir(3'b000, ic);
    chk("R6 top bit is pad3 enable", 32'(pad_oe), 32'(4'b1000));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule